// File: doc/BRIEF.md
# Width-Switchable Serial Port FIFO

This block is the word buffer that sits between a processor-side data register and the shift logic of a serial port. The same 128 bits of storage take one of two shapes, chosen by the programmed serial word-length field. Short words use eight 16-bit entries. Long words use four 32-bit entries, and each long entry packs two 16-bit storage halves.

On the transmit side, the processor writes into the write end of the queue. On the receive side, the processor reads the head of the queue. Both ends use a simple push/pop handshake. A push is accepted only when the queue is not full. A pop is accepted only when the queue is not empty. A rejected request sets a sticky flag, which software clears by writing one. Any change of the word-length field empties the queue, so no entry is ever read in a shape it was not written in.

Top module: `dualwidth_fifo`

## Requirements
- R1: A word-length value below 16 selects narrow mode. In narrow mode the depth is 8 entries, `full` rises after the eighth accepted push, and `pop_data[31:16]` reads zero.
- R2: A word-length value of 16 or more selects wide mode. In wide mode the depth is 4 entries of 32 bits, and `full` rises after the fourth accepted push.
- R3: Accepted words leave the queue in the order they were accepted, including after the pointers wrap. `pop_data` shows the head word while the queue is not empty.
- R4: `count` equals accepted pushes minus accepted pops. `full` is high exactly when `count` equals the depth of the active mode, and `empty` is high exactly when `count` is 0.
- R5: A push while `full` is high is discarded and sets `overflow`, which stays high until cleared.
- R6: A pop while `empty` is high is discarded and sets `underflow`, which stays high until cleared.
- R7: A high `clr_overflow` or `clr_underflow` clears the matching flag at the next edge. If the flag is set again in the same cycle, setting wins.
- R8: In a cycle where `word_len` differs from its value in the previous cycle, the queue is emptied, and any push or pop in that cycle is discarded without setting a flag.
- R9: In narrow mode only `push_data[15:0]` is stored, and the upper input bits have no effect on what is read back.
- R10: After reset the queue is empty, `count` is 0, both flags are low, and the registered word length is 0.
- R11: Acceptance of a push or a pop is judged from the state at the start of the cycle. A push and a pop that are both accepted leave `count` unchanged. A push together with a pop on a full queue moves the pop and rejects the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_len | input | 5 | Programmed serial word length; selects the shape |
| push | input | 1 | Write-end request |
| push_data | input | 32 | Word to store (low 16 bits in narrow mode) |
| pop | input | 1 | Read-end request |
| pop_data | output | 32 | Head word, zero-extended in narrow mode |
| full | output | 1 | Queue holds the active depth |
| empty | output | 1 | Queue holds no entry |
| count | output | 4 | Number of stored entries |
| overflow | output | 1 | Sticky: a push was refused |
| underflow | output | 1 | Sticky: a pop was refused |
| clr_overflow | input | 1 | Write-one-to-clear for `overflow` |
| clr_underflow | input | 1 | Write-one-to-clear for `underflow` |

## Verification
The embedded properties check the following on every cycle:
- the occupancy never exceeds the active depth;
- a refused push leaves a full queue full, and a refused pop leaves an empty queue empty;
- a word-length change always leaves the queue empty;
- the sticky flags follow their set-wins-over-clear rule.

Data ordering, packing of two halves into one wide entry, and zero extension of narrow words can only be shown by the bench. The bench sweeps word-length values across both shapes with mixed push/pop patterns and compares every head word against a reference queue.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  localparam int HALF_W   = 16;
  localparam int HALVES   = 8;
  localparam int LEN_W    = 5;
  localparam int WIDE_MIN = 16;

  // active depth: wide entries use two halves each
  function automatic int depth_of(input logic wide, input int halves);
    return wide ? halves / 2 : halves;
  endfunction

  // pointer advance with wrap at the active depth
  function automatic int ptr_step(input int p, input int lim);
    return (p >= lim - 1) ? 0 : p + 1;
  endfunction

  function automatic logic is_wide(input int len, input int wide_min);
    return len >= wide_min;
  endfunction
endpackage

// File: rtl/wsf_ptrs.sv
module wsf_ptrs
  import wsf_pkg::*;
#(
  parameter int HALVES_P = HALVES,
  localparam int PTR_W   = $clog2(HALVES_P),
  localparam int CNT_W   = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             push_rej,
  output logic             pop_rej
);
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] depth_c;
  int               lim;

  always_comb begin
    lim     = depth_of(wide, HALVES_P);
    depth_c = CNT_W'(lim);
  end

  assign full     = (cnt_q == depth_c);
  assign empty    = (cnt_q == '0);
  assign push_ok  = push && !full  && !flush;
  assign pop_ok   = pop  && !empty && !flush;
  assign push_rej = push &&  full  && !flush;
  assign pop_rej  = pop  &&  empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= PTR_W'(ptr_step(int'(wptr_q), lim));
      if (pop_ok)  rptr_q <= PTR_W'(ptr_step(int'(rptr_q), lim));
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign count = cnt_q;

  // R4: occupancy bounded by the active depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth_c);
  // R5: refused push keeps the queue full
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_rej && !pop) |=> full);
  // R6: refused pop keeps the queue empty
  a_r6_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_rej && !push) |=> empty);
  // R8: a flush always leaves nothing stored
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  // R11: accepted push and pop together keep the count
  a_r11_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/wsf_store.sv
module wsf_store
  import wsf_pkg::*;
#(
  parameter int HALF_W_P = HALF_W,
  parameter int HALVES_P = HALVES,
  localparam int PTR_W   = $clog2(HALVES_P),
  localparam int FULL_W  = 2 * HALF_W_P
) (
  input  logic              clk,
  input  logic              wide,
  input  logic              we,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [FULL_W-1:0] wdata,
  input  logic [PTR_W-1:0]  rptr,
  output logic [FULL_W-1:0] rdata
);
  logic [HALF_W_P-1:0] mem [HALVES_P];
  logic [PTR_W-1:0]    lo_idx, hi_idx;

  // a wide entry j occupies halves 2j (low) and 2j+1 (high)
  always_ff @(posedge clk) begin
    for (int h = 0; h < HALVES_P; h++) begin
      if (we) begin
        if (wide) begin
          if (PTR_W'(h / 2) == wptr) mem[h] <= wdata[(h % 2) * HALF_W_P +: HALF_W_P];
        end else begin
          if (PTR_W'(h) == wptr) mem[h] <= wdata[HALF_W_P-1:0];
        end
      end
    end
  end

  assign lo_idx = {rptr[PTR_W-2:0], 1'b0};
  assign hi_idx = {rptr[PTR_W-2:0], 1'b1};

  always_comb begin
    if (wide) rdata = {mem[hi_idx], mem[lo_idx]};
    else      rdata = {{HALF_W_P{1'b0}}, mem[rptr]};
  end
endmodule

// File: rtl/dualwidth_fifo.sv
module dualwidth_fifo
  import wsf_pkg::*;
#(
  parameter int HALF_W_P   = HALF_W,
  parameter int HALVES_P   = HALVES,
  parameter int LEN_W_P    = LEN_W,
  parameter int WIDE_MIN_P = WIDE_MIN,
  localparam int PTR_W     = $clog2(HALVES_P),
  localparam int CNT_W     = PTR_W + 1,
  localparam int FULL_W    = 2 * HALF_W_P
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W_P-1:0] word_len,
  input  logic               push,
  input  logic [FULL_W-1:0]  push_data,
  input  logic               pop,
  output logic [FULL_W-1:0]  pop_data,
  output logic               full,
  output logic               empty,
  output logic [CNT_W-1:0]   count,
  output logic               overflow,
  output logic               underflow,
  input  logic               clr_overflow,
  input  logic               clr_underflow
);
  logic [LEN_W_P-1:0] len_q;
  logic               flush, wide_q;
  logic [PTR_W-1:0]   wptr, rptr;
  logic               push_ok, pop_ok, push_rej, pop_rej;
  logic               ovf_q, unf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= word_len;
  end

  assign flush  = (word_len != len_q);
  assign wide_q = is_wide(int'(len_q), WIDE_MIN_P);

  wsf_ptrs #(.HALVES_P(HALVES_P)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wide(wide_q), .flush(flush),
    .push(push), .pop(pop), .wptr(wptr), .rptr(rptr), .count(count),
    .full(full), .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok),
    .push_rej(push_rej), .pop_rej(pop_rej)
  );

  wsf_store #(.HALF_W_P(HALF_W_P), .HALVES_P(HALVES_P)) u_store (
    .clk(clk), .wide(wide_q), .we(push_ok), .wptr(wptr),
    .wdata(push_data), .rptr(rptr), .rdata(pop_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (push_rej)          ovf_q <= 1'b1;
      else if (clr_overflow) ovf_q <= 1'b0;
      if (pop_rej)            unf_q <= 1'b1;
      else if (clr_underflow) unf_q <= 1'b0;
    end
  end

  assign overflow  = ovf_q;
  assign underflow = unf_q;

  // R7: set has priority over clear
  a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    push_rej |=> overflow);
  a_r7_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
    pop_rej |=> underflow);
  a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_overflow && !push_rej) |=> !overflow);
  // R8: a word-length change never raises a flag by itself
  a_r8_flush_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !overflow && !clr_overflow) |=> !overflow);
endmodule

// File: tb/dualwidth_fifo_tb.sv
module dualwidth_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  word_len = 5'd5;
  logic        push = 1'b0, pop = 1'b0;
  logic [31:0] push_data = '0;
  logic [31:0] pop_data;
  logic        full, empty, overflow, underflow;
  logic [3:0]  count;
  logic        clr_overflow = 1'b0, clr_underflow = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] q[$];
  int wl_m = 0;
  bit ovf_m = 0, unf_m = 0;

  always #2 clk = ~clk;

  dualwidth_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .word_len(word_len), .push(push),
    .push_data(push_data), .pop(pop), .pop_data(pop_data), .full(full),
    .empty(empty), .count(count), .overflow(overflow), .underflow(underflow),
    .clr_overflow(clr_overflow), .clr_underflow(clr_underflow)
  );

  function automatic int dep(int wl);
    return (wl >= 16) ? 4 : 8;
  endfunction

  function automatic logic [31:0] shape(int wl, logic [31:0] d);
    return (wl >= 16) ? d : {16'h0, d[15:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // called at a falling edge; applies one cycle and checks the state after it
  task automatic step(bit pu, logic [31:0] d, bit po, bit co, bit cu, string tag);
    bit fl, uok, pok, urej, prej;
    int depth;
    if (po && q.size() > 0 && int'(word_len) == wl_m)
      chk({tag, " R3 head"}, pop_data, q[0]);
    push = pu; push_data = d; pop = po; clr_overflow = co; clr_underflow = cu;
    @(posedge clk);
    fl = (int'(word_len) != wl_m);
    depth = dep(wl_m);
    uok = 0; pok = 0; urej = 0; prej = 0;
    if (fl) q.delete();
    else begin
      pok  = po && q.size() > 0;
      prej = po && q.size() == 0;
      uok  = pu && q.size() < depth;
      urej = pu && q.size() >= depth;
      if (pok) void'(q.pop_front());
      if (uok) q.push_back(shape(wl_m, d));
    end
    if (urej) ovf_m = 1; else if (co) ovf_m = 0;
    if (prej) unf_m = 1; else if (cu) unf_m = 0;
    wl_m = int'(word_len);
    @(negedge clk);
    push = 0; pop = 0; clr_overflow = 0; clr_underflow = 0;
    chk({tag, " R4 count"}, 32'(count), 32'(q.size()));
    chk({tag, " R4 full"},  32'(full),  32'(q.size() == dep(wl_m)));
    chk({tag, " R4 empty"}, 32'(empty), 32'(q.size() == 0));
    chk({tag, " R5 ovf"},   32'(overflow),  32'(ovf_m));
    chk({tag, " R6 unf"},   32'(underflow), 32'(unf_m));
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 empty", 32'(empty), 32'd1);
    chk("R10 count", 32'(count), 32'd0);
    chk("R10 flags", {30'd0, overflow, underflow}, 32'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R10");   // registered length 0 -> 5: flush
    step(0, 0, 0, 0, 0, "R10");

    // R1 / R9: narrow fill with junk upper bits
    for (int i = 0; i < 8; i++) step(1, 32'hABCD_0000 | 32'(i * 257), 0, 0, 0, "R1");
    chk("R1 full after 8", 32'(full), 32'd1);
    step(1, 32'h1111_2222, 0, 0, 0, "R5");   // refused push
    chk("R5 overflow set", 32'(overflow), 32'd1);
    step(1, 32'h3333_4444, 1, 0, 0, "R11");  // full: pop moves, push refused
    for (int i = 0; i < 7; i++) begin
      chk("R1 upper zero", {16'h0, pop_data[31:16]}, 32'h0);
      step(0, 0, 1, 0, 0, "R9");
    end
    step(0, 0, 1, 0, 0, "R6");               // refused pop
    chk("R6 underflow set", 32'(underflow), 32'd1);
    step(1, 32'h5, 0, 1, 1, "R7");           // clear both
    chk("R7 cleared", {30'd0, overflow, underflow}, 32'd0);
    step(0, 0, 1, 0, 0, "R11");
    step(0, 0, 1, 0, 1, "R7");               // set and clear same cycle
    chk("R7 set wins", 32'(underflow), 32'd1);
    step(0, 0, 0, 0, 1, "R7");

    // R2: wide shape
    word_len = 5'd24;
    step(0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, 32'hC0DE_0000 + 32'(i), 0, 0, 0, "R2");
    chk("R2 full after 4", 32'(full), 32'd1);
    chk("R2 wide head", pop_data, 32'hC0DE_0000);
    step(1, 32'h1, 1, 0, 0, "R11");
    step(1, 32'h2, 1, 0, 0, "R11");

    // R8: flush with data and a push in the change cycle
    word_len = 5'd31;
    step(1, 32'h7777_7777, 1, 0, 1, "R8");
    chk("R8 emptied", 32'(count), 32'd0);
    chk("R8 no flag", 32'(underflow), 32'd0);

    // sweep of lengths and push/pop patterns (R3 wrap, R4)
    for (int wl = 2; wl < 32; wl += 3) begin
      word_len = 5'(wl);
      step(0, 0, 0, 1, 1, "R8");
      for (int i = 0; i < 30; i++)
        step(((i * 7) % 5) != 0, {8'(wl), 8'(i), 16'(i * 37 + wl)},
             (((i * 3) % 4) == 0) || (i > 20), 0, 0, "R3");
    end
    summary();
  end
endmodule